// File: doc/BRIEF.md
# Scatter-Gather Chain Walker

This block follows a chain of 16-byte scatter-gather descriptors held in memory and converts them into a sequence of address and length requests for a downstream DMA mover. Software, or a command engine, starts a walk by giving a table pointer, the total number of bytes the command moves, and whether the command writes or reads. The walker then fetches one descriptor per memory access. A data descriptor becomes one request. A link descriptor redirects the fetch pointer to another table. The walk ends at the descriptor flagged as terminal.

Each walk ends with a one-cycle `done` pulse that carries an error code. Code 0 means the chain and the byte count agree. Code 7 means a write command ran out of descriptors and code 8 means a read command ran out. Code 16 means a table pointer was not aligned to 8 bytes.

The controller is a six-state machine:

| State | Role |
|---|---|
| `ST_IDLE` | Waits for `start`. |
| `ST_FETCH` | Presents the descriptor address on the memory port. |
| `ST_WAIT` | Waits for the response and classifies the descriptor. |
| `ST_ISSUE` | Holds a data request until the DMA mover accepts it. |
| `ST_CLOSE` | Compares the remaining byte count against zero. |
| `ST_DONE` | Raises the completion pulse. |

The transitions are:

- IDLE→FETCH on an aligned start, and IDLE→DONE on a misaligned start.
- FETCH→WAIT when the memory port accepts the request.
- WAIT→FETCH on an aligned link, or on a skipped descriptor that is not terminal.
- WAIT→ISSUE on a data descriptor with a nonzero effective length.
- WAIT→CLOSE on a skipped terminal descriptor.
- WAIT→DONE on a misaligned link.
- ISSUE→FETCH on acceptance of a non-terminal request, and ISSUE→CLOSE on acceptance of a terminal one.
- CLOSE→DONE always, then DONE→IDLE.

Top module: `sg_chain_walker`

## Requirements
- R1: The walker fetches descriptors through the memory port at the current pointer. Each response word carries the buffer address in bits [63:0], the byte count in bits [95:64] and the flags in bits [127:96]. After a non-link descriptor, the next fetch address is the previous one plus 16.
- R2: A data descriptor with a nonzero effective length produces exactly one request on `dreq_*`. Address, length and discard stay stable while `dreq_valid` is high and `dreq_ready` is low. No descriptor fetch is issued while a request is pending.
- R3: Flag bit 29 (discard) makes the request carry `dreq_discard`=1 and `dreq_addr`=0. The descriptor's address is ignored.
- R4: Flag bit 30 (link) makes no request. The descriptor's address becomes the next fetch pointer. Link takes precedence over the terminal and discard flags of the same descriptor.
- R5: A descriptor whose effective length is zero makes no request. This happens when its count is zero or when no bytes remain. The walk then continues with the next descriptor, or finishes if flag bit 31 is set.
- R6: The effective length is the smaller of the descriptor count and the bytes remaining. The remaining count drops by that amount when the request is accepted.
- R7: Once a descriptor with flag bit 31 (terminal) has been consumed, the walk completes with error code 0 if no bytes remain.
- R8: If bytes remain when the terminal descriptor has been consumed, the error code is 7 for a write command (`start_write`=1) and 8 for a read command.
- R9: A start pointer or link address with a nonzero value in bits [2:0] ends the walk with error code 16 without fetching from that address. A misaligned start reports `done` one cycle after `start`.
- R10: `done` is high for exactly one cycle per walk, and `err_code` is valid in that cycle. `start` is ignored while `busy` is high.
- R11: After reset the walker is idle: `busy`, `done`, `mem_req_valid` and `dreq_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| start_ptr | input | 64 | Address of the first descriptor |
| start_len | input | 32 | Total bytes of the command |
| start_write | input | 1 | 1 = write command, 0 = read command |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Descriptor fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 64 | Descriptor fetch address |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 128 | Descriptor word |
| dreq_valid | output | 1 | Data request valid |
| dreq_ready | input | 1 | DMA mover accepts the request |
| dreq_addr | output | 64 | Buffer address (0 when discarding) |
| dreq_len | output | 32 | Request length in bytes |
| dreq_discard | output | 1 | Data of this request is dropped |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 6 | 0, 7, 8 or 16, valid with `done` |

## Verification
The fetch request is due in the cycle after `start` is sampled. A data request is due in the cycle after its descriptor response. `done` comes two cycles after the terminal request is accepted, or one cycle after a misaligned start.

The bench drives inputs and samples outputs on the falling edge, where every output is stable. It records each handshake in the cycle it occurs and compares the ordered request stream, the fetch count, the error code and the width of the `done` pulse against a bench-side walk of the same memory image. For a misaligned start it also measures the one-cycle latency of `done` exactly.

// File: rtl/sgw_pkg.sv
`timescale 1ns/1ps
package sgw_pkg;
    // descriptor word layout
    localparam int ENTRY_W      = 128;
    localparam int CNT_LSB      = 64;
    localparam int FLAG_LSB     = 96;
    localparam int FLAG_LAST    = 31;
    localparam int FLAG_LINK    = 30;
    localparam int FLAG_DISCARD = 29;
    localparam int ENTRY_BYTES  = 16;
    localparam int ALIGN_BITS   = 3;

    localparam int ERR_W = 6;
    localparam logic [ERR_W-1:0] ERR_NONE     = 6'd0;
    localparam logic [ERR_W-1:0] ERR_WR_SHORT = 6'd7;
    localparam logic [ERR_W-1:0] ERR_RD_SHORT = 6'd8;
    localparam logic [ERR_W-1:0] ERR_ALIGN    = 6'd16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_ISSUE,
        ST_CLOSE,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/sgw_entry_decode.sv
`timescale 1ns/1ps
module sgw_entry_decode
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic [LEN_W-1:0]   rem_i,
    output logic [ADDR_W-1:0]  buf_addr_o,
    output logic [LEN_W-1:0]   eff_len_o,
    output logic               last_o,
    output logic               link_o,
    output logic               discard_o,
    output logic               link_misaligned_o
);
    logic [LEN_W-1:0] cnt;
    logic [31:0]      flags;
    logic             unused_bits;

    assign buf_addr_o        = entry_i[ADDR_W-1:0];
    assign cnt               = entry_i[CNT_LSB +: LEN_W];
    assign flags             = entry_i[FLAG_LSB +: 32];
    assign last_o            = flags[FLAG_LAST];
    assign link_o            = flags[FLAG_LINK];
    assign discard_o         = flags[FLAG_DISCARD];
    assign link_misaligned_o = |buf_addr_o[ALIGN_BITS-1:0];
    assign unused_bits       = ^flags[FLAG_DISCARD-1:0];

    // clip the descriptor to what the command still needs
    always_comb begin
        if (cnt < rem_i) eff_len_o = cnt;
        else             eff_len_o = rem_i;
    end
endmodule

// File: rtl/sgw_len_tracker.sv
`timescale 1ns/1ps
module sgw_len_tracker #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic [LEN_W-1:0] dec_val_i,
    output logic [LEN_W-1:0] rem_o,
    output logic             rem_zero_o
);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      rem_q <= '0;
        else if (load_i) rem_q <= load_val_i;
        else if (dec_i)  rem_q <= rem_q - dec_val_i;
    end

    assign rem_o      = rem_q;
    assign rem_zero_o = (rem_q == '0);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (dec_val_i <= rem_q));
endmodule

// File: rtl/sgw_ptr_unit.sv
`timescale 1ns/1ps
module sgw_ptr_unit #(
    parameter int ADDR_W = 64,
    parameter int STEP   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (load_i) ptr_q <= load_val_i;
        else if (adv_i)  ptr_q <= ptr_q + STEP_V;
    end

    assign ptr_o = ptr_q;

    // R1
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (ptr_q == $past(ptr_q) + STEP_V));
endmodule

// File: rtl/sg_chain_walker.sv
`timescale 1ns/1ps
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_ptr,
    input  logic [LEN_W-1:0]   start_len,
    input  logic               start_write,
    output logic               busy,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               dreq_valid,
    input  logic               dreq_ready,
    output logic [ADDR_W-1:0]  dreq_addr,
    output logic [LEN_W-1:0]   dreq_len,
    output logic               dreq_discard,
    output logic               done,
    output logic [ERR_W-1:0]   err_code
);
    walk_state_e state_q, state_d;
    logic [ERR_W-1:0] err_q, err_d;
    logic             wr_q;

    // captured data descriptor
    logic [ADDR_W-1:0] ent_addr_q;
    logic [LEN_W-1:0]  ent_len_q;
    logic              ent_disc_q;
    logic              ent_last_q;

    // control strobes
    logic              ptr_load, ptr_adv, rem_load, rem_dec, ent_cap;
    logic [ADDR_W-1:0] ptr_val;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  rem;
    logic              rem_zero;

    // decoded response
    logic [ADDR_W-1:0] dec_addr;
    logic [LEN_W-1:0]  dec_eff_len;
    logic              dec_last, dec_link, dec_disc, dec_link_mis;

    sgw_entry_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_decode (
        .entry_i           (mem_rsp_data),
        .rem_i             (rem),
        .buf_addr_o        (dec_addr),
        .eff_len_o         (dec_eff_len),
        .last_o            (dec_last),
        .link_o            (dec_link),
        .discard_o         (dec_disc),
        .link_misaligned_o (dec_link_mis)
    );

    sgw_len_tracker #(.LEN_W(LEN_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (rem_load),
        .load_val_i (start_len),
        .dec_i      (rem_dec),
        .dec_val_i  (ent_len_q),
        .rem_o      (rem),
        .rem_zero_o (rem_zero)
    );

    sgw_ptr_unit #(.ADDR_W(ADDR_W), .STEP(ENTRY_BYTES)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (ptr_val),
        .adv_i      (ptr_adv),
        .ptr_o      (ptr)
    );

    // next-state and control
    always_comb begin
        state_d  = state_q;
        err_d    = err_q;
        ptr_load = 1'b0;
        ptr_val  = start_ptr;
        ptr_adv  = 1'b0;
        rem_load = 1'b0;
        rem_dec  = 1'b0;
        ent_cap  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (|start_ptr[ALIGN_BITS-1:0]) begin
                        err_d   = ERR_ALIGN;
                        state_d = ST_DONE;
                    end else begin
                        ptr_load = 1'b1;
                        rem_load = 1'b1;
                        err_d    = ERR_NONE;
                        state_d  = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (dec_link) begin
                        if (dec_link_mis) begin
                            err_d   = ERR_ALIGN;
                            state_d = ST_DONE;
                        end else begin
                            ptr_load = 1'b1;
                            ptr_val  = dec_addr;
                            state_d  = ST_FETCH;
                        end
                    end else if (dec_eff_len == '0) begin
                        if (dec_last) begin
                            state_d = ST_CLOSE;
                        end else begin
                            ptr_adv = 1'b1;
                            state_d = ST_FETCH;
                        end
                    end else begin
                        ent_cap = 1'b1;
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (dreq_ready) begin
                    rem_dec = 1'b1;
                    if (ent_last_q) begin
                        state_d = ST_CLOSE;
                    end else begin
                        ptr_adv = 1'b1;
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_CLOSE: begin
                if (rem_zero)  err_d = ERR_NONE;
                else if (wr_q) err_d = ERR_WR_SHORT;
                else           err_d = ERR_RD_SHORT;
                state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // command and descriptor capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q       <= 1'b0;
            ent_addr_q <= '0;
            ent_len_q  <= '0;
            ent_disc_q <= 1'b0;
            ent_last_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) wr_q <= start_write;
            if (ent_cap) begin
                ent_addr_q <= dec_disc ? '0 : dec_addr;
                ent_len_q  <= dec_eff_len;
                ent_disc_q <= dec_disc;
                ent_last_q <= dec_last;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_FETCH);
        mem_req_addr  = ptr;
        dreq_valid    = (state_q == ST_ISSUE);
        dreq_addr     = ent_addr_q;
        dreq_len      = ent_len_q;
        dreq_discard  = ent_disc_q;
        done          = (state_q == ST_DONE);
        err_code      = (state_q == ST_DONE) ? err_q : ERR_NONE;
    end

    // R2
    dreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_valid && !dreq_ready) |=> (dreq_valid && $stable(dreq_addr)
                                         && $stable(dreq_len) && $stable(dreq_discard)));

    // R2
    no_fetch_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && dreq_valid));

    // R9
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ALIGN_BITS-1:0] == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    clean_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == ERR_NONE) |-> rem_zero);

    // R3
    discard_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_valid && dreq_discard) |-> (dreq_addr == '0));
endmodule

// File: tb/sg_chain_walker_tb.sv
`timescale 1ns/1ps
module sg_chain_walker_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [63:0]  start_ptr;
    logic [31:0]  start_len;
    logic         start_write;
    logic         busy;
    logic         mem_req_valid;
    logic         mem_req_ready;
    logic [63:0]  mem_req_addr;
    logic         mem_rsp_valid;
    logic [127:0] mem_rsp_data;
    logic         dreq_valid;
    logic         dreq_ready;
    logic [63:0]  dreq_addr;
    logic [31:0]  dreq_len;
    logic         dreq_discard;
    logic         done;
    logic [5:0]   err_code;

    always #2.5 clk = ~clk;
    assign mem_req_ready = 1'b1;

    sg_chain_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
        .start_len(start_len), .start_write(start_write), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .dreq_valid(dreq_valid),
        .dreq_ready(dreq_ready), .dreq_addr(dreq_addr), .dreq_len(dreq_len),
        .dreq_discard(dreq_discard), .done(done), .err_code(err_code)
    );

    // descriptor memory, 64 slots of 16 bytes
    logic [127:0] mem [64];

    // observed log
    logic [63:0] got_addr [1024];
    logic [31:0] got_len  [1024];
    logic        got_disc [1024];
    int          got_n = 0, fetch_n = 0, done_n = 0;
    logic [5:0]  got_err = '0;
    logic        pend = 1'b0;
    logic [5:0]  pend_idx = '0;

    // expected
    logic [63:0] ex_addr [64];
    logic [31:0] ex_len  [64];
    logic        ex_disc [64];
    int          ex_n, ex_fetch;
    logic [5:0]  ex_err;

    int checks = 0, fails = 0;
    bit hung = 1'b0;

    always @(negedge clk) begin
        mem_rsp_valid = pend;
        mem_rsp_data  = pend ? mem[pend_idx] : '0;
        pend          = mem_req_valid && mem_req_ready;
        pend_idx      = mem_req_addr[9:4];
        if (mem_req_valid) fetch_n++;
        dreq_ready = ($urandom % 4) != 0;
        if (dreq_valid && dreq_ready) begin
            got_addr[got_n % 1024] = dreq_addr;
            got_len [got_n % 1024] = dreq_len;
            got_disc[got_n % 1024] = dreq_discard;
            got_n++;
        end
        if (done) begin
            done_n++;
            got_err = err_code;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [127:0] ent(input logic [63:0] a, input logic [31:0] c,
                                         input bit last, input bit link, input bit disc);
        return {last, link, disc, 29'd0, c, a};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    // bench-side walk of the descriptor chain
    task automatic model(input logic [63:0] ptr, input logic [31:0] len, input bit wr);
        logic [63:0] p;
        logic [31:0] rem, eff, c;
        logic [127:0] e;
        p = ptr; rem = len; ex_n = 0; ex_fetch = 0; ex_err = 6'd0;
        if (p[2:0] != 3'd0) begin ex_err = 6'd16; return; end
        for (int step = 0; step < 200; step++) begin
            e = mem[p[9:4]];
            ex_fetch++;
            if (e[126]) begin
                if (e[2:0] != 3'd0) begin ex_err = 6'd16; return; end
                p = e[63:0];
                continue;
            end
            c = e[95:64];
            eff = (c < rem) ? c : rem;
            if (eff != 0) begin
                ex_addr[ex_n] = e[125] ? 64'd0 : e[63:0];
                ex_len[ex_n]  = eff;
                ex_disc[ex_n] = e[125];
                ex_n++;
                rem = rem - eff;
            end
            if (e[127]) begin
                ex_err = (rem == 0) ? 6'd0 : (wr ? 6'd7 : 6'd8);
                return;
            end
            p = p + 64'd16;
        end
    endtask

    task automatic run_case(input logic [63:0] ptr, input logic [31:0] len, input bit wr,
                            input string tag, input bit poke, input bit want_lat);
        int b_got, b_fetch, b_done, lat;
        if (hung) return;
        model(ptr, len, wr);
        b_got = got_n; b_fetch = fetch_n; b_done = done_n;
        @(negedge clk);
        start = 1'b1; start_ptr = ptr; start_len = len; start_write = wr;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (poke && lat == 3) begin
                start = 1'b1; start_ptr = 64'h4; start_len = 32'd5; start_write = ~wr;
            end
        end while (!done && lat < 3000);
        start = 1'b0;
        if (!done) begin
            hung = 1'b1;
            chk(1'b0, {tag, " watchdog expired"}, 64'(lat), 64'd0);
            return;
        end
        if (want_lat) chk(lat == 1, "R9 done latency after misaligned start", 64'(lat), 64'd1);
        repeat (3) @(negedge clk);
        chk((got_n - b_got) == ex_n, {tag, " R2 request count"}, 64'(got_n - b_got), 64'(ex_n));
        for (int i = 0; i < ex_n && i < (got_n - b_got); i++) begin
            chk(got_addr[(b_got+i)%1024] == ex_addr[i], {tag, " R2 request address"},
                got_addr[(b_got+i)%1024], ex_addr[i]);
            chk(got_len[(b_got+i)%1024] == ex_len[i], {tag, " R6 request length"},
                64'(got_len[(b_got+i)%1024]), 64'(ex_len[i]));
            chk(got_disc[(b_got+i)%1024] == ex_disc[i], {tag, " R3 discard flag"},
                64'(got_disc[(b_got+i)%1024]), 64'(ex_disc[i]));
        end
        chk((fetch_n - b_fetch) == ex_fetch, {tag, " R1 fetch count"},
            64'(fetch_n - b_fetch), 64'(ex_fetch));
        chk(got_err == ex_err, {tag, " error code"}, 64'(got_err), 64'(ex_err));
        chk((done_n - b_done) == 1, {tag, " R10 done pulse width"}, 64'(done_n - b_done), 64'd1);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic basic_chain();
        clear_mem();
        mem[16] = ent(64'h1000, 32'd64, 0, 0, 0);
        mem[17] = ent(64'h2000, 32'd32, 0, 0, 0);
        mem[18] = ent(64'h3000, 32'd16, 1, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; start_ptr = '0; start_len = '0; start_write = 1'b0;
        dreq_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        clear_mem();
        repeat (5) @(negedge clk);
        chk(!busy && !done, "R11 busy/done after reset", {62'd0, busy, done}, 64'd0);
        chk(!mem_req_valid && !dreq_valid, "R11 request valids after reset",
            {62'd0, mem_req_valid, dreq_valid}, 64'd0);
        rst_n = 1'b1;

        // R7 exact fit, write
        basic_chain();
        run_case(64'h100, 32'd112, 1'b1, "R7", 1'b0, 1'b0);
        // R8 read short, write short
        run_case(64'h100, 32'd200, 1'b0, "R8", 1'b0, 1'b0);
        run_case(64'h100, 32'd200, 1'b1, "R8", 1'b0, 1'b0);
        // R10 start pulse while busy is ignored
        run_case(64'h100, 32'd112, 1'b1, "R10", 1'b1, 1'b0);
        // R9 misaligned start pointer
        run_case(64'h104, 32'd16, 1'b1, "R9", 1'b0, 1'b1);
        // R4 link with last and discard flags also set
        clear_mem();
        mem[16] = ent(64'h1000, 32'd10, 0, 0, 0);
        mem[17] = ent(64'h200, 32'd99, 1, 1, 1);
        mem[32] = ent(64'h4000, 32'd20, 1, 0, 0);
        run_case(64'h100, 32'd30, 1'b0, "R4", 1'b0, 1'b0);
        // R9 misaligned link
        clear_mem();
        mem[16] = ent(64'h20C, 32'd8, 0, 1, 0);
        run_case(64'h100, 32'd8, 1'b0, "R9", 1'b0, 1'b0);
        // R5 zero-count descriptors skipped, terminal skip included
        clear_mem();
        mem[16] = ent(64'h1000, 32'd0, 0, 0, 0);
        mem[17] = ent(64'h2000, 32'd8, 0, 0, 0);
        mem[18] = ent(64'h3000, 32'd0, 1, 0, 0);
        run_case(64'h100, 32'd8, 1'b1, "R5", 1'b0, 1'b0);
        // R5 nothing remaining makes later descriptors silent
        clear_mem();
        mem[16] = ent(64'h1000, 32'd8, 0, 0, 0);
        mem[17] = ent(64'h2000, 32'd8, 0, 0, 0);
        mem[18] = ent(64'h3000, 32'd8, 1, 0, 0);
        run_case(64'h100, 32'd8, 1'b0, "R5", 1'b0, 1'b0);
        // R3 discard
        clear_mem();
        mem[16] = ent(64'hABC0, 32'd40, 1, 0, 1);
        run_case(64'h100, 32'd40, 1'b0, "R3", 1'b0, 1'b0);
        // R6 clipping
        clear_mem();
        mem[16] = ent(64'h1000, 32'd100, 0, 0, 0);
        mem[17] = ent(64'h2000, 32'd100, 1, 0, 0);
        run_case(64'h100, 32'd150, 1'b1, "R6", 1'b0, 1'b0);

        // random chains
        for (int t = 0; t < 40; t++) begin
            int n, cur, tgt, sel;
            logic [31:0] sum, cnt, len;
            clear_mem();
            n = 1 + int'($urandom % 10);
            cur = 16; sum = 0;
            for (int k = 0; k < n; k++) begin
                if (k < n - 1 && ($urandom % 5) == 0) begin
                    tgt = cur + 2 + int'($urandom % 2);
                    mem[cur] = ent(64'(tgt * 16), $urandom, $urandom % 2 == 0, 1'b1, $urandom % 2 == 0);
                    cur = tgt;
                end else begin
                    cnt = (($urandom % 5) == 0) ? 32'd0 : ($urandom % 300);
                    mem[cur] = ent(rnd64(), cnt, k == n - 1, 1'b0, ($urandom % 3) == 0);
                    sum = sum + cnt;
                    cur++;
                end
            end
            sel = int'($urandom % 3);
            if (sel == 0)      len = sum;
            else if (sel == 1) len = sum + 1 + ($urandom % 50);
            else               len = (sum > 0) ? ($urandom % sum) : 0;
            run_case(64'h100, len, $urandom % 2 == 0, "R6 random", 1'b0, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule